// File: doc/BRIEF.md
# Multi-function I/O line router

This block shares four bidirectional digital lines between three special functions and plain general-purpose use. The special functions are a data-ready output that signals each new sample, an alarm output that mirrors an alarm flag, and an external sample-clock input. Each function has an enable, a polarity or edge choice and a two-bit line selector. A line that no enabled function claims falls back to a general-purpose layer, which gives it a direction and an output level.

A host writes two registers through a simple register port: a 16-bit function map and an 8-bit general-purpose register. Reading the general-purpose register returns the synchronized pin levels in place of the stored levels. The block produces the sample tick that the rest of the chip uses. This tick is the internal sample strobe, or, when the external clock input is enabled, the selected edge of the chosen line. When the external input is enabled, the internal strobe has no effect. Data-ready is a pulse of fixed length that starts after each sample tick.

Top module: `io_line_router`

## Requirements
- R1: After reset the function map reads 0x000D and the general-purpose register reads 0x0000 with all pins low. Line 2 is then an enabled data-ready output, active high and idle low, and the other lines are inputs.
- R2: Function map bits [1:0] choose the data-ready line, bit 2 sets its polarity (1 = active high) and bit 3 enables it. For every selector, code 0, 1, 2 and 3 means line 1, 2, 3 and 4, and line n is pin bit n-1.
- R3: Function map bits [5:4] choose the external sample-clock line, bit 6 picks the edge (1 = rising, 0 = falling) and bit 7 enables it.
- R4: Function map bits [9:8] choose the alarm line, bit 10 sets its polarity (1 = active high) and bit 11 enables it. Bits [15:12] are discarded on write and read as zero.
- R5: Every sample tick starts a data-ready pulse on the next clock edge that lasts DRDY_LEN cycles. A new tick restarts the pulse. The line shows the active level during the pulse and the inactive level otherwise.
- R6: An enabled alarm line is driven with the alarm flag, registered once, and inverted when the polarity bit is 0.
- R7: When the alarm and data-ready are both enabled on the same line, the alarm drives that line.
- R8: While the external input is enabled, the internal strobe is suppressed. A tick occurs for one cycle, two clock edges after the selected edge reaches the pin. The pin passes through two synchronizing flops first. The other edge produces no tick.
- R9: If the external input selects a line that an enabled output function claims, it never produces a tick, and the internal strobe stays suppressed.
- R10: On an unclaimed line, general-purpose bit n-1 (bits [3:0]) sets the output enable of line n, and bit n+3 (bits [7:4]) sets the level it drives. An unclaimed input line drives 0.
- R11: Reading the general-purpose register returns the direction bits in [3:0] and the pin levels in [7:4], delayed by two clock edges. Bits [15:8] read as zero.
- R12: The line chosen by an enabled, unblocked external input is always an input, whatever its direction bit says.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_wsel | input | 1 | Write target: 0 = function map, 1 = general-purpose |
| reg_wdata | input | 16 | Write data |
| reg_rsel | input | 1 | Read target: 0 = function map, 1 = general-purpose |
| reg_rdata | output | 16 | Read data, combinational |
| pin_in | input | 4 | Levels seen on the four lines |
| pin_oe | output | 4 | Per-line output enable |
| pin_out | output | 4 | Per-line output value |
| int_strobe | input | 1 | Internal sample strobe |
| alarm_flag | input | 1 | Alarm condition |
| sample_tick | output | 1 | Sample tick in effect |

## Verification
The alarm and data-ready outputs can claim the same line in the same cycle. The bench sets up this conflict in its vector table by putting both functions on line 3 with opposite polarities. With opposite polarities, the idle level of each function differs, so the value on the pin shows which function won. The bench judges the result by driving the alarm flag both ways. The pin must follow the alarm in both cases, and it must stay on the alarm even when data-ready alone would have driven the other level.

// File: rtl/io_router_pkg.sv
package io_router_pkg;

    localparam int unsigned IOR_LINES = 4;
    localparam int unsigned IOR_SEL_W = $clog2(IOR_LINES);
    localparam int unsigned IOR_REG_W = 16;

    typedef logic [IOR_SEL_W-1:0] line_sel_t;

    // one special function: enable, polarity/edge, line selector
    typedef struct packed {
        logic      en;
        logic      pol;
        line_sel_t sel;
    } fn_cfg_t;

    // packed order is the register layout: alarm [11:8], sync [7:4], drdy [3:0]
    typedef struct packed {
        fn_cfg_t alarm;
        fn_cfg_t sync;
        fn_cfg_t drdy;
    } fn_map_t;

    localparam int unsigned IOR_MAP_W = $bits(fn_map_t);
    localparam int unsigned IOR_GP_W  = 2 * IOR_LINES;

    localparam fn_map_t IOR_MAP_RST = '{
        alarm: '{en: 1'b0, pol: 1'b0, sel: '0},
        sync:  '{en: 1'b0, pol: 1'b0, sel: '0},
        drdy:  '{en: 1'b1, pol: 1'b1, sel: line_sel_t'(1)}
    };

    function automatic logic fn_claims(fn_cfg_t f, line_sel_t line);
        return f.en && (f.sel == line);
    endfunction

endpackage

// File: rtl/io_reg_bank.sv
module io_reg_bank
    import io_router_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [IOR_REG_W-1:0] wr_data,
    output fn_map_t              map,
    output logic [IOR_LINES-1:0] gp_dir,
    output logic [IOR_LINES-1:0] gp_lvl
);

    typedef struct packed {
        fn_map_t              map;
        logic [IOR_LINES-1:0] dir;
        logic [IOR_LINES-1:0] lvl;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  wdata_unused_bits;

    assign wdata_unused_bits = ^wr_data[IOR_REG_W-1:IOR_MAP_W];

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            if (!wr_sel) begin
                bank_d.map = fn_map_t'(wr_data[IOR_MAP_W-1:0]);
            end else begin
                bank_d.dir = wr_data[IOR_LINES-1:0];
                bank_d.lvl = wr_data[IOR_GP_W-1:IOR_LINES];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '{map: IOR_MAP_RST, dir: '0, lvl: '0};
        end else begin
            bank_q <= bank_d;
        end
    end

    assign map    = bank_q.map;
    assign gp_dir = bank_q.dir;
    assign gp_lvl = bank_q.lvl;

    // R1
    map_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bank_q.map == IOR_MAP_RST));

    // R4
    map_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (bank_q.map == $past(wr_data[IOR_MAP_W-1:0])));

endmodule

// File: rtl/io_pin_sync.sv
module io_pin_sync
    import io_router_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IOR_LINES-1:0] pin_in,
    input  line_sel_t            edge_sel,
    input  logic                 edge_rise,
    output logic [IOR_LINES-1:0] pin_lvl,
    output logic                 edge_hit
);

    typedef struct packed {
        logic [IOR_LINES-1:0] meta;
        logic [IOR_LINES-1:0] lvl;
        logic [IOR_LINES-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  cur_lvl, old_lvl;

    always_comb begin
        sync_d.meta = pin_in;
        sync_d.lvl  = sync_q.meta;
        sync_d.prev = sync_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    always_comb begin
        cur_lvl  = sync_q.lvl[edge_sel];
        old_lvl  = sync_q.prev[edge_sel];
        edge_hit = edge_rise ? (cur_lvl & ~old_lvl) : (~cur_lvl & old_lvl);
    end

    assign pin_lvl = sync_q.lvl;

    // R8
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit ##1 ($stable(edge_sel) && $stable(edge_rise)) |-> !edge_hit);

endmodule

// File: rtl/io_drdy_gen.sv
module io_drdy_gen #(
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic active
);

    localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (tick) begin
            cnt_d = CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign active = (cnt_q != '0);

    // R5
    drdy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> active);

    // R5
    drdy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LOAD);

endmodule

// File: rtl/io_line_mux.sv
module io_line_mux
    import io_router_pkg::*;
(
    input  fn_map_t              map,
    input  logic [IOR_LINES-1:0] gp_dir,
    input  logic [IOR_LINES-1:0] gp_lvl,
    input  logic                 drdy_on,
    input  logic                 alarm_on,
    output logic [IOR_LINES-1:0] line_oe,
    output logic [IOR_LINES-1:0] line_out,
    output logic                 sync_blocked
);

    logic drdy_lvl, alarm_lvl;

    assign drdy_lvl  = map.drdy.pol  ? drdy_on  : ~drdy_on;
    assign alarm_lvl = map.alarm.pol ? alarm_on : ~alarm_on;

    assign sync_blocked = fn_claims(map.alarm, map.sync.sel)
                        | fn_claims(map.drdy, map.sync.sel);

    for (genvar i = 0; i < IOR_LINES; i++) begin : g_line
        localparam line_sel_t IDX = line_sel_t'(i);
        logic oe_l, out_l;

        always_comb begin
            if (fn_claims(map.alarm, IDX)) begin
                oe_l  = 1'b1;
                out_l = alarm_lvl;
            end else if (fn_claims(map.drdy, IDX)) begin
                oe_l  = 1'b1;
                out_l = drdy_lvl;
            end else if (fn_claims(map.sync, IDX)) begin
                oe_l  = 1'b0;
                out_l = 1'b0;
            end else begin
                oe_l  = gp_dir[i];
                out_l = gp_dir[i] & gp_lvl[i];
            end
        end

        assign line_oe[i]  = oe_l;
        assign line_out[i] = out_l;
    end

endmodule

// File: rtl/io_line_router.sv
module io_line_router
    import io_router_pkg::*;
#(
    parameter int unsigned DRDY_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_wsel,
    input  logic [IOR_REG_W-1:0] reg_wdata,
    input  logic                 reg_rsel,
    output logic [IOR_REG_W-1:0] reg_rdata,
    input  logic [IOR_LINES-1:0] pin_in,
    output logic [IOR_LINES-1:0] pin_oe,
    output logic [IOR_LINES-1:0] pin_out,
    input  logic                 int_strobe,
    input  logic                 alarm_flag,
    output logic                 sample_tick
);

    fn_map_t              map;
    logic [IOR_LINES-1:0] gp_dir, gp_lvl, pin_lvl;
    logic                 edge_hit, drdy_on, sync_blocked;
    logic                 alarm_d, alarm_q;

    io_reg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_sel  (reg_wsel),
        .wr_data (reg_wdata),
        .map     (map),
        .gp_dir  (gp_dir),
        .gp_lvl  (gp_lvl)
    );

    io_pin_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .edge_sel  (map.sync.sel),
        .edge_rise (map.sync.pol),
        .pin_lvl   (pin_lvl),
        .edge_hit  (edge_hit)
    );

    always_comb begin
        if (map.sync.en) begin
            sample_tick = edge_hit & ~sync_blocked;
        end else begin
            sample_tick = int_strobe;
        end
    end

    io_drdy_gen #(.PULSE_LEN(DRDY_LEN)) u_drdy (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sample_tick),
        .active (drdy_on)
    );

    always_comb alarm_d = alarm_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= 1'b0;
        end else begin
            alarm_q <= alarm_d;
        end
    end

    io_line_mux u_mux (
        .map          (map),
        .gp_dir       (gp_dir),
        .gp_lvl       (gp_lvl),
        .drdy_on      (drdy_on),
        .alarm_on     (alarm_q),
        .line_oe      (pin_oe),
        .line_out     (pin_out),
        .sync_blocked (sync_blocked)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rsel) begin
            reg_rdata[IOR_LINES-1:0]         = gp_dir;
            reg_rdata[IOR_GP_W-1:IOR_LINES]  = pin_lvl;
        end else begin
            reg_rdata[IOR_MAP_W-1:0]         = map;
        end
    end

    // R6 R7
    alarm_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map.alarm.en |-> (pin_oe[map.alarm.sel] &&
            (pin_out[map.alarm.sel] == (map.alarm.pol ? alarm_q : !alarm_q))));

    // R8
    strobe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map.sync.en && int_strobe && !edge_hit) |-> !sample_tick);

    // R9
    sync_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map.sync.en && sync_blocked) |-> !sample_tick);

    // R12
    sync_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map.sync.en && !sync_blocked) |-> !pin_oe[map.sync.sel]);

endmodule

// File: tb/sim_io_line_router.sv
module sim_io_line_router;

    localparam int DRDY_LEN = 4;
    localparam int NVEC     = 10;

    // {fmap[15:0], gp[7:0], alarm[3:0], exp_oe[3:0], exp_out[3:0]}
    localparam logic [35:0] VEC [0:NVEC-1] = '{
        {16'h000D, 8'h00, 4'h0, 4'b0010, 4'b0000},  // R2 default drdy idle
        {16'h0008, 8'h00, 4'h0, 4'b0001, 4'b0001},  // R2 line1 active low idle
        {16'h0E03, 8'h00, 4'h1, 4'b0100, 4'b0100},  // R6 alarm line3 high
        {16'h0E03, 8'h00, 4'h0, 4'b0100, 4'b0000},  // R6
        {16'h0E0A, 8'h00, 4'h0, 4'b0100, 4'b0000},  // R7 alarm over drdy
        {16'h0E0A, 8'h00, 4'h1, 4'b0100, 4'b0100},  // R7
        {16'h0000, 8'h5F, 4'h0, 4'b1111, 4'b0101},  // R10 gp only
        {16'h0B08, 8'h5F, 4'h0, 4'b1111, 4'b1101},  // R10 mixed
        {16'h00D0, 8'hFF, 4'h0, 4'b1101, 4'b1101},  // R12 sync line is input
        {16'h0CC0, 8'h00, 4'h1, 4'b0001, 4'b0001}   // R9 sync under alarm
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_wsel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        reg_rsel = 1'b0;
    logic [15:0] reg_rdata;
    logic [3:0]  pin_in = '0;
    logic [3:0]  pin_oe, pin_out;
    logic        int_strobe = 1'b0;
    logic        alarm_flag = 1'b0;
    logic        sample_tick;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    io_line_router #(.DRDY_LEN(DRDY_LEN)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_wsel    (reg_wsel),
        .reg_wdata   (reg_wdata),
        .reg_rsel    (reg_rsel),
        .reg_rdata   (reg_rdata),
        .pin_in      (pin_in),
        .pin_oe      (pin_oe),
        .pin_out     (pin_out),
        .int_strobe  (int_strobe),
        .alarm_flag  (alarm_flag),
        .sample_tick (sample_tick)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] data);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wsel  = sel;
        reg_wdata = data;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [15:0] data);
        reg_rsel = sel;
        #1;
        data = reg_rdata;
    endtask

    task automatic count_ticks(input int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (sample_tick) c++;
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] rv;
        int          c;

        // reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(1'b0, rv); chk("R1 fmap reset", rv, 16'h000D);
        rd(1'b1, rv); chk("R1 gp reset", rv, 16'h0000);
        chk("R1 oe reset", {12'h0, pin_oe}, 16'h0002);
        chk("R1 out reset", {12'h0, pin_out}, 16'h0000);

        // R4 upper bits discarded
        wr(1'b0, 16'hF00D);
        rd(1'b0, rv); chk("R4 upper bits dropped", rv, 16'h000D);
        wr(1'b0, 16'hFFFF);
        rd(1'b0, rv); chk("R4 all bits", rv, 16'h0FFF);

        // static routing table
        for (int i = 0; i < NVEC; i++) begin
            wr(1'b0, VEC[i][35:20]);
            wr(1'b1, {8'h00, VEC[i][19:12]});
            alarm_flag = VEC[i][8];
            @(negedge clk);
            @(negedge clk);
            chk($sformatf("R2 R6 R7 R10 R12 vec%0d oe", i), {12'h0, pin_oe}, {12'h0, VEC[i][7:4]});
            chk($sformatf("R2 R6 R7 R10 R12 vec%0d out", i), {12'h0, pin_out}, {12'h0, VEC[i][3:0]});
        end
        alarm_flag = 1'b0;

        // R5 data-ready pulse, active high on line 2
        wr(1'b1, 16'h0000);
        wr(1'b0, 16'h000D);
        int_strobe = 1'b1;
        #1 chk("R8 internal strobe passes", {15'h0, sample_tick}, 16'h1);
        @(negedge clk);
        int_strobe = 1'b0;
        for (int k = 0; k < DRDY_LEN; k++) begin
            chk($sformatf("R5 drdy high cycle %0d", k), {15'h0, pin_out[1]}, 16'h1);
            @(negedge clk);
        end
        chk("R5 drdy ends", {15'h0, pin_out[1]}, 16'h0);

        // R5 active low on line 4
        wr(1'b0, 16'h000B);
        chk("R5 low idle", {15'h0, pin_out[3]}, 16'h1);
        int_strobe = 1'b1;
        @(negedge clk);
        int_strobe = 1'b0;
        for (int k = 0; k < DRDY_LEN; k++) begin
            chk($sformatf("R5 drdy low cycle %0d", k), {15'h0, pin_out[3]}, 16'h0);
            @(negedge clk);
        end
        chk("R5 low drdy ends", {15'h0, pin_out[3]}, 16'h1);

        // R11 pin level readback latency
        wr(1'b1, 16'h0003);
        pin_in = 4'b1010;
        @(negedge clk);
        rd(1'b1, rv); chk("R11 readback after one edge", rv, 16'h0003);
        @(negedge clk);
        rd(1'b1, rv); chk("R11 readback after two edges", rv, 16'h00A3);
        pin_in = 4'b0000;
        repeat (3) @(negedge clk);

        // R3 R8 external rising edge on line 1, drdy on line 2
        wr(1'b0, 16'h00CD);
        int_strobe = 1'b1;
        #1 chk("R8 strobe suppressed", {15'h0, sample_tick}, 16'h0);
        @(negedge clk);
        int_strobe = 1'b0;
        chk("R8 no drdy from strobe", {15'h0, pin_out[1]}, 16'h0);
        pin_in[0] = 1'b1;
        @(negedge clk);
        chk("R8 no tick after one edge", {15'h0, sample_tick}, 16'h0);
        @(negedge clk);
        chk("R8 tick after two edges", {15'h0, sample_tick}, 16'h1);
        @(negedge clk);
        chk("R8 tick one cycle", {15'h0, sample_tick}, 16'h0);
        chk("R5 drdy from external edge", {15'h0, pin_out[1]}, 16'h1);
        pin_in[0] = 1'b0;
        count_ticks(6, c);
        chk("R3 falling ignored in rising mode", 16'(c), 16'd0);

        // R3 falling mode
        wr(1'b0, 16'h008D);
        pin_in[0] = 1'b1;
        count_ticks(6, c);
        chk("R3 rising ignored in falling mode", 16'(c), 16'd0);
        pin_in[0] = 1'b0;
        count_ticks(6, c);
        chk("R3 falling counted", 16'(c), 16'd1);

        // R9 sync on a line owned by data-ready
        wr(1'b0, 16'h00DD);
        pin_in[1] = 1'b1;
        count_ticks(5, c);
        pin_in[1] = 1'b0;
        begin
            int c2;
            count_ticks(5, c2);
            c = c + c2;
        end
        int_strobe = 1'b1;
        count_ticks(2, c);
        int_strobe = 1'b0;
        chk("R9 blocked sync no ticks", 16'(c), 16'd0);
        chk("R9 line kept as output", {15'h0, pin_oe[1]}, 16'h1);

        finish_run();
    end

endmodule